// File: doc/BRIEF.md
# Pseudo-Random Logic Self-Test Controller

This block tests a small combinational circuit on its own. A three-stage linear-feedback pattern generator supplies the circuit's inputs. Every cycle, the circuit's three response bits are folded into a three-stage multiple-input signature register. The run lasts a fixed number of cycles. At the end, the final signature is compared with a constant supplied at elaboration time, and one pass/fail bit reports the result. Individual responses are never checked one by one; only the compacted signature is judged.

A pulse on `start` while the controller is idle begins a run. `busy` stays high while the run is in progress. `done` marks the end with a single-cycle pulse, and `pass` keeps its verdict until the next accepted start. A small voting circuit (`vote3_cut`) is provided as the circuit under test so the pair can be exercised standalone. The two are wired through the `pat_o` and `resp_i` buses.

Top module: `lfsr_selftest`

## Requirements
- R1: After reset, `busy`, `done` and `pass` are 0, and `pat_o` is 3'b111. Bit i of `pat_o` is stage i of the generator.
- R2: A `start` sampled high while `busy` is low sets `busy` on the next edge. The same edge reseeds the generator to 3'b111, clears the signature to 0 and clears `pass`.
- R3: On each busy edge the generator steps: stage0 takes stage1, stage1 takes stage2, and stage2 takes stage0 XOR stage2. From the seed, `pat_o` therefore reads 7, 3, 5, 2, 1, 4, 6, and the step after 6 returns to 7.
- R4: `pat_o` is never zero.
- R5: On each busy edge the signature s updates with response r as follows: s0 takes s1^r0, s1 takes s2^r1, and s2 takes s0^s2^r2. The signature absorbs the response to the pattern on `pat_o` during that cycle.
- R6: A run holds `busy` high for exactly 7 cycles. `done` is high for exactly one cycle, in the cycle in which `busy` first reads low again.
- R7: `pass` becomes 1 with `done` only if the final signature equals `EXP_SIG`. It holds its value until the next accepted start.
- R8: A `start` that arrives while `busy` is high has no effect: the run length, the pattern sequence and the verdict are unchanged.
- R9: A stuck-at fault on any input or output net of the circuit under test that changes the final signature makes `pass` read 0.
- R10: The circuit under test, on input a, drives r0 = majority(a0,a1,a2), r1 = a0^a1^a2 and r2 = a0 & ~a1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Run request, honoured only when idle |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| pass | output | 1 | Verdict of the last run |
| pat_o | output | 3 | Pattern to the circuit under test |
| resp_i | input | 3 | Response from the circuit under test |

## Verification
The bench builds the controller with its default seed and run length. It sets `EXP_SIG` to a signature that a reference model of the generator, the voting circuit and the compactor computes at elaboration. With that value the fault-free run must pass. The bench then injects stuck-at values on each of the six nets between controller and circuit, which makes failing verdicts and possible aliasing reachable and checks each against the model's prediction. Mid-run start pulses exercise the ignore rule.

// File: rtl/vote3_cut.sv
module vote3_cut (
  input  logic [2:0] a,
  output logic [2:0] r
);
  assign r[0] = (a[0] & a[1]) | (a[0] & a[2]) | (a[1] & a[2]);
  assign r[1] = ^a;
  assign r[2] = a[0] & ~a[1];
endmodule

// File: rtl/lfsr_selftest.sv
module lfsr_selftest #(
  parameter logic [2:0]  SEED    = 3'b111,
  parameter int unsigned RUN_LEN = 7,
  parameter logic [2:0]  EXP_SIG = 3'b000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  output logic       busy,
  output logic       done,
  output logic       pass,
  output logic [2:0] pat_o,
  input  logic [2:0] resp_i
);
  localparam int CW = $clog2(RUN_LEN + 1);
  localparam logic [2:0] SEED_OK = (SEED == 3'b000) ? 3'b111 : SEED;

  logic [2:0]    gen_q, sig_q, gen_nx, sig_nx;
  logic [CW-1:0] cnt_q;
  logic          go, last;

  assign go     = start & ~busy;
  assign last   = busy && (cnt_q == CW'(RUN_LEN - 1));
  assign gen_nx = {gen_q[0] ^ gen_q[2], gen_q[2], gen_q[1]};
  assign sig_nx = {sig_q[0] ^ sig_q[2] ^ resp_i[2],
                   sig_q[2] ^ resp_i[1],
                   sig_q[1] ^ resp_i[0]};
  assign pat_o  = gen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gen_q <= SEED_OK;
      sig_q <= '0;
      cnt_q <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
      pass  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go) begin
        busy  <= 1'b1;
        gen_q <= SEED_OK;
        sig_q <= '0;
        cnt_q <= '0;
        pass  <= 1'b0;
      end else if (busy) begin
        gen_q <= gen_nx;
        sig_q <= sig_nx;
        cnt_q <= cnt_q + 1'b1;
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
          pass <= (sig_nx == EXP_SIG);
        end
      end
    end
  end
endmodule

module lfsr_selftest_chk #(
  parameter int unsigned RUN_LEN = 7
) (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic       pass,
  input logic [2:0] pat_o
);
  localparam int RW = $clog2(RUN_LEN + 2);
  logic [RW-1:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_cnt <= '0;
    else if (busy) run_cnt <= run_cnt + 1'b1;
    else           run_cnt <= '0;
  end

  // R2
  start_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  // R4
  pat_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pat_o != 3'b000);
  // R6
  run_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (run_cnt == RW'(RUN_LEN)));
  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R6
  fall_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  // R7
  pass_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && !$rose(busy)) |-> $stable(pass));
endmodule

bind lfsr_selftest lfsr_selftest_chk #(.RUN_LEN(RUN_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
  .done(done), .pass(pass), .pat_o(pat_o)
);

// File: tb/lfsr_selftest_tb.sv
`timescale 1ns/1ps
module lfsr_selftest_tb;
  function automatic logic [2:0] m_step(input logic [2:0] g);
    return {g[0] ^ g[2], g[2], g[1]};
  endfunction
  function automatic logic [2:0] m_cut(input logic [2:0] a);
    logic [2:0] r;
    r[0] = (a[0] & a[1]) | (a[0] & a[2]) | (a[1] & a[2]);
    r[1] = a[0] ^ a[1] ^ a[2];
    r[2] = a[0] & ~a[1];
    return r;
  endfunction
  function automatic logic [2:0] m_misr(input logic [2:0] s, input logic [2:0] r);
    return {s[0] ^ s[2] ^ r[2], s[2] ^ r[1], s[1] ^ r[0]};
  endfunction
  function automatic logic [2:0] m_sig(input bit en, input int site, input bit val);
    logic [2:0] g, s, a, r;
    g = 3'b111; s = 3'b000;
    for (int k = 0; k < 7; k++) begin
      a = g;
      if (en && site < 3) a[site] = val;
      r = m_cut(a);
      if (en && site >= 3) r[site-3] = val;
      s = m_misr(s, r);
      g = m_step(g);
    end
    return s;
  endfunction

  localparam logic [2:0] GOLD = m_sig(1'b0, 0, 1'b0);

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic busy, done, pass;
  logic [2:0] pat_o, resp_i, cut_in, cut_out;
  bit fault_en = 1'b0;
  int fault_site = 0;
  bit fault_val = 1'b0;
  int checks = 0, failures = 0, detected = 0;

  always #2.5 clk = ~clk;

  always_comb begin
    cut_in = pat_o;
    if (fault_en && fault_site < 3) cut_in[fault_site] = fault_val;
    resp_i = cut_out;
    if (fault_en && fault_site >= 3) resp_i[fault_site-3] = fault_val;
  end

  vote3_cut u_cut (.a(cut_in), .r(cut_out));

  lfsr_selftest #(.EXP_SIG(GOLD)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .pass(pass), .pat_o(pat_o), .resp_i(resp_i)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_case(input bit mid_start);
    logic [2:0] g;
    bit exp_pass;
    exp_pass = (m_sig(fault_en, fault_site, fault_val) == GOLD);
    g = 3'b111;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy == 1'b1, "R2 busy after start", busy, 1);
    chk(pass == 1'b0, "R2 pass cleared", pass, 0);
    for (int k = 0; k < 7; k++) begin
      if (k > 0) begin
        @(negedge clk); start = 1'b0;
        chk(busy == 1'b1 && done == 1'b0, "R6 busy during run", {busy, done}, 2);
      end
      chk(pat_o == g, "R3 pattern", pat_o, g);
      chk(pat_o != 3'b000, "R4 nonzero pattern", pat_o, 1);
      if (!fault_en) chk(resp_i == m_cut(pat_o), "R10 cut response", resp_i, m_cut(pat_o));
      if (mid_start && k == 3) start = 1'b1;
      g = m_step(g);
    end
    @(negedge clk); start = 1'b0;
    chk(done == 1'b1 && busy == 1'b0, "R6 done with busy low", {busy, done}, 1);
    chk(pass == exp_pass, mid_start ? "R8 verdict with ignored start" : "R7 verdict",
        pass, exp_pass);
    chk(pat_o == 3'b111, "R3 wraps to seed", pat_o, 7);
    if (!pass) detected++;
    repeat (3) @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R6 single done pulse", {busy, done}, 0);
    chk(pass == exp_pass, "R7 pass held", pass, exp_pass);
  endtask

  initial begin
    #(5.0 * 150000);
    failures++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && pass == 0, "R1 reset flags", {busy, done, pass}, 0);
    chk(pat_o == 3'b111, "R1 reset pattern", pat_o, 7);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R1 idle after reset", busy, 0);

    run_case(1'b0);
    chk(pass == 1'b1, "R5 fault-free signature matches", pass, 1);
    run_case(1'b1);
    chk(pass == 1'b1, "R8 mid-run start ignored", pass, 1);

    fault_en = 1'b1; fault_site = 4; fault_val = 1'b0;
    chk(m_sig(1'b1, 4, 1'b0) != GOLD, "R9 model sanity", 0, 1);
    run_case(1'b0);
    chk(pass == 1'b0, "R9 parity stuck-at-0 detected", pass, 0);

    for (int n = 0; n < 30; n++) begin
      fault_en   = ($urandom % 4) != 0;
      fault_site = $urandom % 6;
      fault_val  = $urandom % 2;
      run_case(($urandom % 2) == 1);
    end
    chk(detected > 0, "R9 faults detected", detected, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule